// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken, given only its fetch address. It runs two direction predictors side by side. The first keeps a short per-branch record of past outcomes and uses that record to pick a counter. The second uses the outcomes of recently predicted branches, across the whole program, to pick a counter in its own table. A third table of trained counters decides, branch by branch, which of the two to trust.

A lookup is combinational. Alongside the guess, the predict port returns a checkpoint: both table indices, the global history snapshot and both component guesses. When the branch later resolves, the pipeline returns that checkpoint with the real outcome and a mispredict flag. Training therefore never has to read speculative state again. The global history takes each predicted direction as soon as it is produced. On a mispredict it is rebuilt from the returned snapshot and the real outcome.

Top module: `tournament_dir_predictor`

## Requirements
- R1: After reset every local and global counter is weakly not-taken, every chooser counter weakly favours the local side (MSB 0), and every history is zero. The first lookup after reset therefore returns not-taken, with `pred_lhist` and `pred_ghist` both zero.
- R2: `pred_lidx` is the XOR of the LHT_AW-bit chunks of the address rotated right by two (`{pc[1:0], pc[PC_W-1:2]}`, zero-padded at the top to whole chunks).
- R3: `pred_lpred` is the MSB of the LCNT_W-bit counter addressed by the branch's local history `pred_lhist`.
- R4: `pred_gpred` is the MSB of the GCNT_W-bit counter addressed by the global history `pred_ghist`.
- R5: `pred_taken` equals `pred_gpred` when the MSB of the chooser counter at `pred_cidx` is 1, and equals `pred_lpred` otherwise. With the default variant, `pred_cidx` equals `pred_ghist`.
- R6: On a resolve, the chooser counter at `upd_cidx` goes up by one when only the global guess was right, goes down by one when only the local guess was right, and is left unchanged otherwise.
- R7: A lookup in a cycle with no mispredict shifts `pred_taken` into bit 0 of the global history, and the history is visible on `pred_ghist` from the next cycle.
- R8: A resolve with `upd_mispredict` set loads the global history with `{upd_ghist[GHIST_W-2:0], upd_taken}`. This takes priority over a lookup in the same cycle.
- R9: A branch's local history changes only at resolve time: the real outcome is shifted into bit 0 of entry `upd_lidx`. A lookup never alters it.
- R10: On a resolve, the local and global counters addressed by the checkpoint count up when the branch was taken and down when it was not. Every counter saturates at all-ones and at zero.
- R11: A resolve without a mispredict leaves the global history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_valid | input | 1 | A lookup happens this cycle |
| pred_pc | input | PC_W | Fetch address of the branch |
| pred_taken | output | 1 | Predicted direction |
| pred_lidx | output | LHT_AW | Checkpoint: local history table index |
| pred_lhist | output | LHIST_W | Checkpoint: local history of the branch |
| pred_ghist | output | GHIST_W | Checkpoint: global history snapshot |
| pred_cidx | output | GHIST_W | Checkpoint: chooser table index |
| pred_lpred | output | 1 | Checkpoint: local component guess |
| pred_gpred | output | 1 | Checkpoint: global component guess |
| upd_valid | input | 1 | A branch resolves this cycle |
| upd_lidx | input | LHT_AW | Returned local history table index |
| upd_lhist | input | LHIST_W | Returned local history |
| upd_ghist | input | GHIST_W | Returned global history snapshot |
| upd_cidx | input | GHIST_W | Returned chooser index |
| upd_lpred | input | 1 | Returned local guess |
| upd_gpred | input | 1 | Returned global guess |
| upd_taken | input | 1 | Real outcome |
| upd_mispredict | input | 1 | The final prediction was wrong |

## Verification
The hardest case to reach is a repair that lands in the same cycle as a fresh lookup, with further branches from the wrong path still in flight. The history must come from the returned snapshot, not from the speculative shift. The stimulus keeps up to three unresolved branches pending, resolves the oldest while issuing a new lookup, and drops the younger pending entries whenever a mispredict occurs. Some branch streams follow fixed or correlated patterns and others are random, so chooser counters move in both directions and counters reach both saturation ends. A second reset in the middle of the run checks that all trained state is cleared.

// File: rtl/tbp_pkg.sv
`timescale 1ns/1ps
package tbp_pkg;
   typedef enum logic [1:0] {
      CNT_HOLD = 2'd0,
      CNT_UP   = 2'd1,
      CNT_DOWN = 2'd2
   } cnt_op_e;
endpackage

// File: rtl/tbp_sat_table.sv
`timescale 1ns/1ps
module tbp_sat_table
   import tbp_pkg::*;
#(
   parameter int CW = 2,
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd_idx,
   output logic          rd_msb,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_idx,
   input  cnt_op_e       wr_op
);
   localparam int            DEPTH   = 1 << AW;
   localparam logic [CW-1:0] MAXV    = '1;
   localparam logic [CW-1:0] MINV    = '0;
   localparam logic [CW-1:0] WEAK_LO = {1'b0, {(CW-1){1'b1}}};

   if (CW < 2) begin : g_bad_cw
      $error("tbp_sat_table: CW must be at least 2");
   end
   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("tbp_sat_table: AW out of range");
   end

   logic [CW-1:0] mem [DEPTH];
   logic [CW-1:0] wr_cur;

   assign wr_cur = mem[wr_idx];
   assign rd_msb = mem[rd_idx][CW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= WEAK_LO;
      end else if (wr_en) begin
         unique case (wr_op)
            CNT_UP:   if (wr_cur != MAXV) mem[wr_idx] <= wr_cur + 1'b1;
            CNT_DOWN: if (wr_cur != MINV) mem[wr_idx] <= wr_cur - 1'b1;
            default:  ;
         endcase
      end
   end

   // R10: a counter at all-ones stays there on an up step
   a_r10_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op == CNT_UP && wr_cur == MAXV) |=> mem[$past(wr_idx)] == MAXV);
   // R10: a counter at zero stays there on a down step
   a_r10_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op == CNT_DOWN && wr_cur == MINV) |=> mem[$past(wr_idx)] == MINV);
   // R6: a hold step leaves the addressed counter untouched
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op == CNT_HOLD) |=> mem[$past(wr_idx)] == $past(wr_cur));
endmodule

// File: rtl/tbp_hist_table.sv
`timescale 1ns/1ps
module tbp_hist_table #(
   parameter int HW = 10,
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd_idx,
   output logic [HW-1:0] rd_hist,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_idx,
   input  logic          wr_bit
);
   localparam int DEPTH = 1 << AW;

   if (HW < 2) begin : g_bad_hw
      $error("tbp_hist_table: HW must be at least 2");
   end

   logic [HW-1:0] mem [DEPTH];

   assign rd_hist = mem[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_idx] <= {mem[wr_idx][HW-2:0], wr_bit};
      end
   end

   // R9: with no resolve write, a steady index reads a steady history
   a_r9_no_spec_write: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!wr_en) && rd_idx == $past(rd_idx)) |-> rd_hist == $past(rd_hist));
endmodule

// File: rtl/tbp_ghist.sv
`timescale 1ns/1ps
module tbp_ghist #(
   parameter int GW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          spec_en,
   input  logic          spec_bit,
   input  logic          fix_en,
   input  logic [GW-1:0] fix_base,
   input  logic          fix_bit,
   output logic [GW-1:0] hist
);
   if (GW < 2) begin : g_bad_gw
      $error("tbp_ghist: GW must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hist <= '0;
      else if (fix_en)  hist <= {fix_base[GW-2:0], fix_bit};
      else if (spec_en) hist <= {hist[GW-2:0], spec_bit};
   end

   // R7: speculative shift of the predicted direction
   a_r7_spec_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (spec_en && !fix_en) |=> hist == {$past(hist[GW-2:0]), $past(spec_bit)});
   // R8: repair from the snapshot wins over a same-cycle lookup
   a_r8_repair: assert property (@(posedge clk) disable iff (!rst_n)
      fix_en |=> hist == {$past(fix_base[GW-2:0]), $past(fix_bit)});
   // R11: no lookup and no repair keeps the history
   a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!spec_en && !fix_en) |=> $stable(hist));
endmodule

// File: rtl/tournament_dir_predictor.sv
`timescale 1ns/1ps
module tournament_dir_predictor
   import tbp_pkg::*;
#(
   parameter int PC_W         = 32,
   parameter int LHT_AW       = 8,
   parameter int LHIST_W      = 8,
   parameter int GHIST_W      = 10,
   parameter int LCNT_W       = 3,
   parameter int GCNT_W       = 2,
   parameter int CCNT_W       = 2,
   parameter bit CHOICE_BY_PC = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pred_valid,
   input  logic [PC_W-1:0]    pred_pc,
   output logic               pred_taken,
   output logic [LHT_AW-1:0]  pred_lidx,
   output logic [LHIST_W-1:0] pred_lhist,
   output logic [GHIST_W-1:0] pred_ghist,
   output logic [GHIST_W-1:0] pred_cidx,
   output logic               pred_lpred,
   output logic               pred_gpred,
   input  logic               upd_valid,
   input  logic [LHT_AW-1:0]  upd_lidx,
   input  logic [LHIST_W-1:0] upd_lhist,
   input  logic [GHIST_W-1:0] upd_ghist,
   input  logic [GHIST_W-1:0] upd_cidx,
   input  logic               upd_lpred,
   input  logic               upd_gpred,
   input  logic               upd_taken,
   input  logic               upd_mispredict
);
   localparam int NCH   = (PC_W + LHT_AW - 1) / LHT_AW;
   localparam int PAD_W = NCH * LHT_AW;

   if (PC_W < LHT_AW + 2 || PC_W < GHIST_W + 2) begin : g_bad_pc
      $error("tournament_dir_predictor: PC_W too narrow for the indices");
   end

   // ---------------- address fold for the local history index ----------
   logic [PC_W-1:0]   pc_rot;
   logic [PAD_W-1:0]  pc_pad;
   logic [LHT_AW-1:0] fold [NCH+1];

   assign pc_rot  = {pred_pc[1:0], pred_pc[PC_W-1:2]};
   assign fold[0] = '0;

   always_comb begin
      pc_pad             = '0;
      pc_pad[PC_W-1:0]   = pc_rot;
   end

   for (genvar k = 0; k < NCH; k++) begin : g_fold
      assign fold[k+1] = fold[k] ^ pc_pad[k*LHT_AW +: LHT_AW];
   end

   assign pred_lidx = fold[NCH];

   // ---------------- global history ------------------------------------
   logic [GHIST_W-1:0] ghist;

   tbp_ghist #(.GW(GHIST_W)) u_ghist (
      .clk      (clk),
      .rst_n    (rst_n),
      .spec_en  (pred_valid),
      .spec_bit (pred_taken),
      .fix_en   (upd_valid && upd_mispredict),
      .fix_base (upd_ghist),
      .fix_bit  (upd_taken),
      .hist     (ghist)
   );

   assign pred_ghist = ghist;

   // ---------------- chooser index variant -----------------------------
   if (CHOICE_BY_PC) begin : g_cidx_pc
      assign pred_cidx = ghist ^ pc_rot[GHIST_W-1:0];
   end else begin : g_cidx_hist
      assign pred_cidx = ghist;
   end

   // ---------------- local side ----------------------------------------
   tbp_hist_table #(.HW(LHIST_W), .AW(LHT_AW)) u_lht (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (pred_lidx),
      .rd_hist (pred_lhist),
      .wr_en   (upd_valid),
      .wr_idx  (upd_lidx),
      .wr_bit  (upd_taken)
   );

   cnt_op_e dir_op;
   assign dir_op = upd_taken ? CNT_UP : CNT_DOWN;

   tbp_sat_table #(.CW(LCNT_W), .AW(LHIST_W)) u_lct (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (pred_lhist),
      .rd_msb (pred_lpred),
      .wr_en  (upd_valid),
      .wr_idx (upd_lhist),
      .wr_op  (dir_op)
   );

   // ---------------- global side ---------------------------------------
   tbp_sat_table #(.CW(GCNT_W), .AW(GHIST_W)) u_gct (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (ghist),
      .rd_msb (pred_gpred),
      .wr_en  (upd_valid),
      .wr_idx (upd_ghist),
      .wr_op  (dir_op)
   );

   // ---------------- chooser -------------------------------------------
   logic    g_right, l_right, use_global;
   cnt_op_e ch_op;

   assign g_right = (upd_gpred == upd_taken);
   assign l_right = (upd_lpred == upd_taken);

   always_comb begin
      if (g_right && !l_right)      ch_op = CNT_UP;
      else if (l_right && !g_right) ch_op = CNT_DOWN;
      else                          ch_op = CNT_HOLD;
   end

   tbp_sat_table #(.CW(CCNT_W), .AW(GHIST_W)) u_cct (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (pred_cidx),
      .rd_msb (use_global),
      .wr_en  (upd_valid),
      .wr_idx (upd_cidx),
      .wr_op  (ch_op)
   );

   assign pred_taken = use_global ? pred_gpred : pred_lpred;

   // R5: when both components agree the final direction follows them
   a_r5_agree: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_lpred == pred_gpred) |-> pred_taken == pred_lpred);
endmodule

// File: tb/test_tournament_dir_predictor.sv
`timescale 1ns/1ps
module test_tournament_dir_predictor;
   localparam int LA = 8;
   localparam int LH = 8;
   localparam int GH = 10;

   typedef struct {
      logic [LA-1:0] lidx;
      logic [LH-1:0] lh;
      logic [GH-1:0] gh;
      logic [GH-1:0] cidx;
      logic          lp;
      logic          gp;
      logic          dir;
      logic          actual;
   } ck_t;

   typedef struct {
      ck_t   ck;
      string tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pred_valid = 1'b0;
   logic [31:0]   pred_pc = '0;
   logic          pred_taken;
   logic [LA-1:0] pred_lidx;
   logic [LH-1:0] pred_lhist;
   logic [GH-1:0] pred_ghist;
   logic [GH-1:0] pred_cidx;
   logic          pred_lpred, pred_gpred;
   logic          upd_valid = 1'b0;
   logic [LA-1:0] upd_lidx = '0;
   logic [LH-1:0] upd_lhist = '0;
   logic [GH-1:0] upd_ghist = '0;
   logic [GH-1:0] upd_cidx = '0;
   logic          upd_lpred = 1'b0, upd_gpred = 1'b0;
   logic          upd_taken = 1'b0, upd_mispredict = 1'b0;

   always #2.5 clk = ~clk;

   tournament_dir_predictor i_tournament_dir_predictor (
      .clk(clk), .rst_n(rst_n),
      .pred_valid(pred_valid), .pred_pc(pred_pc), .pred_taken(pred_taken),
      .pred_lidx(pred_lidx), .pred_lhist(pred_lhist), .pred_ghist(pred_ghist),
      .pred_cidx(pred_cidx), .pred_lpred(pred_lpred), .pred_gpred(pred_gpred),
      .upd_valid(upd_valid), .upd_lidx(upd_lidx), .upd_lhist(upd_lhist),
      .upd_ghist(upd_ghist), .upd_cidx(upd_cidx), .upd_lpred(upd_lpred),
      .upd_gpred(upd_gpred), .upd_taken(upd_taken), .upd_mispredict(upd_mispredict)
   );

   // ---------------- reference model from the requirements --------------
   logic [LH-1:0] m_lht [1<<LA];
   logic [2:0]    m_lct [1<<LH];
   logic [1:0]    m_gct [1<<GH];
   logic [1:0]    m_cct [1<<GH];
   logic [GH-1:0] m_gh;

   int   n_checks = 0;
   int   n_fail   = 0;
   bit   done     = 0;
   exp_t exp_q [$];
   ck_t  pend  [$];
   bit   after_reset = 0, after_fix = 0, after_quiet = 0;

   task automatic model_reset();
      for (int i = 0; i < (1<<LA); i++) m_lht[i] = '0;
      for (int i = 0; i < (1<<LH); i++) m_lct[i] = 3'b011;
      for (int i = 0; i < (1<<GH); i++) m_gct[i] = 2'b01;
      for (int i = 0; i < (1<<GH); i++) m_cct[i] = 2'b01;
      m_gh = '0;
   endtask

   function automatic logic [LA-1:0] fold(logic [31:0] pc);
      logic [31:0] r = {pc[1:0], pc[31:2]};
      return r[7:0] ^ r[15:8] ^ r[23:16] ^ r[31:24];
   endfunction

   function automatic logic [2:0] step3(logic [2:0] v, logic up);
      if (up)  return (v == 3'd7) ? v : v + 3'd1;
      else     return (v == 3'd0) ? v : v - 3'd1;
   endfunction

   function automatic logic [1:0] step2(logic [1:0] v, logic up);
      if (up)  return (v == 2'd3) ? v : v + 2'd1;
      else     return (v == 2'd0) ? v : v - 2'd1;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // ---------------- driver ----------------------------------------------
   task automatic step(input bit pv, input logic [31:0] pc, input bit actual,
                       input bit uv);
      ck_t   c, u;
      bit    mis = 0;
      string tag = "R5";
      @(negedge clk);
      if (uv && pend.size() > 0) begin
         u   = pend.pop_front();
         mis = (u.dir != u.actual);
      end else begin
         uv = 0;
         u  = '{default: '0};
      end
      pred_valid     = pv;
      pred_pc        = pc;
      upd_valid      = uv;
      upd_lidx       = u.lidx;
      upd_lhist      = u.lh;
      upd_ghist      = u.gh;
      upd_cidx       = u.cidx;
      upd_lpred      = u.lp;
      upd_gpred      = u.gp;
      upd_taken      = u.actual;
      upd_mispredict = mis;
      if (pv) begin
         c.lidx   = fold(pc);
         c.lh     = m_lht[c.lidx];
         c.gh     = m_gh;
         c.cidx   = m_gh;
         c.lp     = m_lct[c.lh][2];
         c.gp     = m_gct[c.gh][1];
         c.dir    = m_cct[c.cidx][1] ? c.gp : c.lp;
         c.actual = actual;
         if (after_reset) tag = {tag, " R1"};
         if (after_fix)   tag = {tag, " R8"};
         if (after_quiet) tag = {tag, " R11"};
         if (m_cct[c.cidx] != 2'b01) tag = {tag, " R6"};
         if (m_lct[c.lh] == 3'd7 || m_lct[c.lh] == 3'd0 ||
             m_gct[c.gh] == 2'd3 || m_gct[c.gh] == 2'd0) tag = {tag, " R10"};
         exp_q.push_back('{c, tag});
         after_reset = 0;
      end
      after_fix   = uv && mis;
      after_quiet = uv && !mis && !pv;
      if (uv) begin
         logic dg = (u.gp == u.actual), dl = (u.lp == u.actual);
         m_lht[u.lidx] = {m_lht[u.lidx][LH-2:0], u.actual};
         m_lct[u.lh]   = step3(m_lct[u.lh], u.actual);
         m_gct[u.gh]   = step2(m_gct[u.gh], u.actual);
         if (dg && !dl)      m_cct[u.cidx] = step2(m_cct[u.cidx], 1'b1);
         else if (dl && !dg) m_cct[u.cidx] = step2(m_cct[u.cidx], 1'b0);
      end
      if (uv && mis) begin
         m_gh = {u.gh[GH-2:0], u.actual};
         pend.delete();
      end else if (pv) begin
         m_gh = {m_gh[GH-2:0], c.dir};
         pend.push_back(c);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; pred_valid = 0; upd_valid = 0; upd_mispredict = 0;
      repeat (3) @(negedge clk);
      model_reset();
      pend.delete();
      rst_n = 1;
      after_reset = 1; after_fix = 0; after_quiet = 0;
   endtask

   // ---------------- monitor -----------------------------------------------
   always begin
      exp_t e;
      @(negedge clk);
      #1;
      if (rst_n && pred_valid && exp_q.size() > 0) begin
         e = exp_q.pop_front();
         check({e.tag, " dir"},      32'(pred_taken), 32'(e.ck.dir));
         check("R2 lidx",            32'(pred_lidx),  32'(e.ck.lidx));
         check("R9 lhist",           32'(pred_lhist), 32'(e.ck.lh));
         check({e.tag, " R7 ghist"}, 32'(pred_ghist), 32'(e.ck.gh));
         check("R5 cidx",            32'(pred_cidx),  32'(e.ck.cidx));
         check("R3 lpred",           32'(pred_lpred), 32'(e.ck.lp));
         check("R4 gpred",           32'(pred_gpred), 32'(e.ck.gp));
      end
   end

   // ---------------- stimulus ------------------------------------------------
   logic [31:0] pcs [6] = '{32'h1000, 32'h1044, 32'h2088, 32'h30cc, 32'h4010, 32'h5154};
   int          cnt [6] = '{default: 0};
   bit          last_a = 0;

   function automatic bit outcome(int i);
      case (i)
         0:       return 1'b1;
         1:       return cnt[1][0];
         2:       return (cnt[2] % 3) != 0;
         3:       return last_a;
         4:       return 1'($urandom_range(0, 1));
         default: return (cnt[5] % 8) == 7;
      endcase
   endfunction

   task automatic run(int n);
      for (int s = 0; s < n; s++) begin
         int  i  = $urandom_range(0, 5);
         bit  pv = ($urandom_range(0, 9) != 0);
         bit  uv = (pend.size() >= 3) || ($urandom_range(0, 2) == 0);
         bit  a  = outcome(i);
         step(pv, pcs[i], a, uv);
         if (pv) begin
            cnt[i]++;
            if (i == 0 || i == 1) last_a = a;
         end
      end
   endtask

   initial begin
      model_reset();
      do_reset();
      // R1: first lookup after reset
      step(1, 32'h0000_0400, 1'b1, 0);
      // R8: mispredicted resolve with a same-cycle lookup
      step(1, 32'h0000_0800, 1'b0, 1);
      step(1, 32'h0000_0c00, 1'b0, 0);
      // R11: correct resolve with no lookup, then look again
      step(0, 32'h0, 1'b0, 1);
      step(1, 32'h0000_0c00, 1'b0, 0);
      // R10: drive one branch to saturation and back
      for (int k = 0; k < 12; k++) begin
         step(1, 32'h0000_7000, 1'b1, 0);
         step(0, 32'h0, 1'b0, 1);
      end
      for (int k = 0; k < 12; k++) begin
         step(1, 32'h0000_7000, 1'b0, 0);
         step(0, 32'h0, 1'b0, 1);
      end
      run(4000);
      // R1: reset after training clears everything
      do_reset();
      step(1, 32'h1000, 1'b1, 0);
      run(500);
      @(negedge clk);
      pred_valid = 0; upd_valid = 0;
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule